// File: doc/BRIEF.md
# Display PHY Bring-Up Sequencer

This block drives the four control lines and the test-clear line of a display PHY and watches two status inputs from the PHY while it starts up. A one-cycle start request launches a fixed ordered sequence. First all control lines are forced low and the test-clear line gives one high pulse. Then every control line is raised at once, and the sequencer waits for PLL lock and after that for the clock lane to reach its stop state.

Each of the two waits has its own programmable cycle limit. When a wait runs past its limit, a sticky error flag for that wait is set and the sequence moves on anyway. When both waits have ended, a done flag rises and the PHY stays enabled. A later start request runs the whole clear-then-enable sequence again.

At each accepted start the block also captures the lane count and stop-wait setting into an interface configuration word, and the data-lane mode-switch timer values into a timer word. The layout of the timer word comes from a parameter. The analog PHY is outside the block.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset, phy_ctrl is 0, phy_testclr is 0, busy, done, err_lock and err_stop are 0, and if_cfg and tmr_cfg are 0.
- R2: A start seen in the idle or done state is accepted. In the first cycle after the accepting edge, phy_ctrl is 0 and phy_testclr is 0. In the second cycle phy_testclr is 1, and in the third it is 0 again. phy_ctrl stays 0 across these three cycles.
- R3: In the fourth cycle after acceptance, all four phy_ctrl bits become 1 together: bit0 releases shutdown, bit1 releases reset, bit2 enables the clock and bit3 forces the PLL. They stay 1 until the next accepted start. phy_ctrl is never any value other than 0 or 4'hF.
- R4: The lock wait starts in the fourth cycle and ends at the first cycle in which phy_lock is 1. The stop-state wait starts in the next cycle and ends at the first cycle in which phy_stop_clk is 1. Cycles within each wait are counted from 0.
- R5: If phy_lock is still 0 when the lock-wait cycle count equals lock_limit, err_lock is set from the next cycle and the stop-state wait begins. If lock arrives in that same cycle, no error is set. err_lock holds until the next accepted start.
- R6: If phy_stop_clk is still 0 when the stop-wait cycle count equals stop_limit, err_stop is set from the next cycle and the sequence completes. If stop state arrives in that same cycle, no error is set. err_stop holds until the next accepted start.
- R7: The cycle after the stop-state wait ends, done is 1 and busy is 0. Both hold, with phy_ctrl at 4'hF, until a new start is accepted. busy is 1 in every cycle from the clear phase through the end of the stop-state wait.
- R8: A start while busy is 1 is ignored, and the sequence continues cycle for cycle as if it had not occurred.
- R9: An accepted start clears done, err_lock and err_stop in the first cycle after the accepting edge, and runs the full sequence again.
- R10: From the first cycle after acceptance, if_cfg holds the stop-wait value sampled at that edge in bits 15:8 and the lane-count-minus-one value in bits 1:0, with all other bits 0. It does not follow later changes of the inputs.
- R11: tmr_cfg is captured at the same edge. With NEW_TIMERS=1, the 10-bit HS-to-LP value is in bits 25:16 and the 10-bit LP-to-HS value is in bits 9:0. With NEW_TIMERS=0, the low 8 bits of HS-to-LP are in 31:24 and the low 8 bits of LP-to-HS are in 23:16. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to run the bring-up sequence |
| lock_limit | input | TO_W | Lock-wait timeout in cycles |
| stop_limit | input | TO_W | Stop-state-wait timeout in cycles |
| cfg_lanes_m1 | input | 2 | Number of data lanes minus one |
| cfg_stop_wait | input | 8 | Stop-wait time field |
| cfg_hs2lp | input | 10 | Data-lane HS-to-LP timer value |
| cfg_lp2hs | input | 10 | Data-lane LP-to-HS timer value |
| phy_lock | input | 1 | PLL lock status from the PHY |
| phy_stop_clk | input | 1 | Clock-lane stop-state status from the PHY |
| phy_ctrl | output | 4 | PHY control lines (bit0 unshutdown, bit1 unreset, bit2 clock enable, bit3 force PLL) |
| phy_testclr | output | 1 | PHY test-clear line |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete |
| err_lock | output | 1 | Sticky: lock wait timed out |
| err_stop | output | 1 | Sticky: stop-state wait timed out |
| if_cfg | output | 16 | Captured interface configuration word |
| tmr_cfg | output | 32 | Captured data-lane timer word |

## Verification
A wrong state register shows up at once on phy_ctrl, phy_testclr, busy or done. The bench compares these outputs every cycle of every run, so a skipped or repeated clear step, or an early enable, fails in the cycle it happens. A timeout counter that is off by one moves the cycle in which done rises and the cycle in which an error flag appears by one, and the cycle-exact trace catches this. A capture register that follows its inputs is exposed by changing the configuration inputs in the middle of a run.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CLR, ST_TCLR_HI, ST_TCLR_LO, ST_WAIT_LOCK, ST_WAIT_STOP, ST_DONE
  } seq_state_e;

  localparam int CTRL_W = 4;
  localparam logic [CTRL_W-1:0] CTRL_ALL_ON = '1;
  localparam int IFCFG_W = 16;
  localparam int TMR_W   = 32;

  // stop wait in 15:8, lanes-1 in 1:0
  function automatic logic [IFCFG_W-1:0] pack_if_cfg(input logic [7:0] stop_wait,
                                                      input logic [1:0] lanes_m1);
    return {stop_wait, 6'b0, lanes_m1};
  endfunction

  // wide layout: hs2lp 25:16, lp2hs 9:0
  function automatic logic [TMR_W-1:0] pack_tmr_wide(input logic [9:0] hs2lp,
                                                      input logic [9:0] lp2hs);
    return {6'b0, hs2lp, 6'b0, lp2hs};
  endfunction

  // narrow layout: hs2lp[7:0] 31:24, lp2hs[7:0] 23:16
  function automatic logic [TMR_W-1:0] pack_tmr_narrow(input logic [9:0] hs2lp,
                                                        input logic [9:0] lp2hs);
    return {hs2lp[7:0], lp2hs[7:0], 16'b0};
  endfunction

endpackage

// File: rtl/phy_wait_timer.sv
module phy_wait_timer #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [TO_W-1:0] limit,
  output logic            expired
);
  logic [TO_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (!expired) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && (cnt_q == limit);
endmodule

// File: rtl/phy_cfg_hold.sv
module phy_cfg_hold
  import phy_seq_pkg::*;
#(
  parameter bit NEW_TIMERS = 1'b1,
  parameter int TO_W       = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [TO_W-1:0]    lock_limit,
  input  logic [TO_W-1:0]    stop_limit,
  input  logic [1:0]         cfg_lanes_m1,
  input  logic [7:0]         cfg_stop_wait,
  input  logic [9:0]         cfg_hs2lp,
  input  logic [9:0]         cfg_lp2hs,
  output logic [TO_W-1:0]    lock_lim_q,
  output logic [TO_W-1:0]    stop_lim_q,
  output logic [IFCFG_W-1:0] if_cfg,
  output logic [TMR_W-1:0]   tmr_cfg
);
  logic [TMR_W-1:0] tmr_next;

  generate
    if (NEW_TIMERS) begin : g_wide
      assign tmr_next = pack_tmr_wide(cfg_hs2lp, cfg_lp2hs);
    end else begin : g_narrow
      assign tmr_next = pack_tmr_narrow(cfg_hs2lp, cfg_lp2hs);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_lim_q <= '0;
      stop_lim_q <= '0;
      if_cfg     <= '0;
      tmr_cfg    <= '0;
    end else if (load) begin
      lock_lim_q <= lock_limit;
      stop_lim_q <= stop_limit;
      if_cfg     <= pack_if_cfg(cfg_stop_wait, cfg_lanes_m1);
      tmr_cfg    <= tmr_next;
    end
  end
endmodule

// File: rtl/phy_seq_fsm.sv
module phy_seq_fsm
  import phy_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              phy_lock,
  input  logic              phy_stop_clk,
  input  logic              lock_expired,
  input  logic              stop_expired,
  output logic              accept,
  output logic              in_wait_lock,
  output logic              in_wait_stop,
  output logic [CTRL_W-1:0] phy_ctrl,
  output logic              phy_testclr,
  output logic              busy,
  output logic              done,
  output logic              err_lock,
  output logic              err_stop
);
  seq_state_e state_q, state_d;
  logic lock_to, stop_to;

  assign busy         = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign accept       = start && !busy;
  assign in_wait_lock = (state_q == ST_WAIT_LOCK);
  assign in_wait_stop = (state_q == ST_WAIT_STOP);
  assign lock_to      = in_wait_lock && !phy_lock && lock_expired;
  assign stop_to      = in_wait_stop && !phy_stop_clk && stop_expired;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (start) state_d = ST_CLR;
      ST_CLR:           state_d = ST_TCLR_HI;
      ST_TCLR_HI:       state_d = ST_TCLR_LO;
      ST_TCLR_LO:       state_d = ST_WAIT_LOCK;
      ST_WAIT_LOCK:     if (phy_lock || lock_expired) state_d = ST_WAIT_STOP;
      ST_WAIT_STOP:     if (phy_stop_clk || stop_expired) state_d = ST_DONE;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      err_lock <= 1'b0;
      err_stop <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        err_lock <= 1'b0;
        err_stop <= 1'b0;
      end else begin
        if (lock_to) err_lock <= 1'b1;
        if (stop_to) err_stop <= 1'b1;
      end
    end
  end

  assign phy_ctrl    = (in_wait_lock || in_wait_stop || state_q == ST_DONE) ? CTRL_ALL_ON : '0;
  assign phy_testclr = (state_q == ST_TCLR_HI);
  assign done        = (state_q == ST_DONE);
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_seq_pkg::*;
#(
  parameter bit NEW_TIMERS = 1'b1,
  parameter int TO_W       = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [TO_W-1:0]    lock_limit,
  input  logic [TO_W-1:0]    stop_limit,
  input  logic [1:0]         cfg_lanes_m1,
  input  logic [7:0]         cfg_stop_wait,
  input  logic [9:0]         cfg_hs2lp,
  input  logic [9:0]         cfg_lp2hs,
  input  logic               phy_lock,
  input  logic               phy_stop_clk,
  output logic [3:0]         phy_ctrl,
  output logic               phy_testclr,
  output logic               busy,
  output logic               done,
  output logic               err_lock,
  output logic               err_stop,
  output logic [15:0]        if_cfg,
  output logic [31:0]        tmr_cfg
);
  // named internal events, observed by the bound checker
  logic            ev_accept;
  logic            ev_wait_lock;
  logic            ev_wait_stop;
  logic            lock_expired, stop_expired;
  logic [TO_W-1:0] lock_lim_q, stop_lim_q;

  phy_cfg_hold #(.NEW_TIMERS(NEW_TIMERS), .TO_W(TO_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(ev_accept),
    .lock_limit(lock_limit), .stop_limit(stop_limit),
    .cfg_lanes_m1(cfg_lanes_m1), .cfg_stop_wait(cfg_stop_wait),
    .cfg_hs2lp(cfg_hs2lp), .cfg_lp2hs(cfg_lp2hs),
    .lock_lim_q(lock_lim_q), .stop_lim_q(stop_lim_q),
    .if_cfg(if_cfg), .tmr_cfg(tmr_cfg)
  );

  phy_wait_timer #(.TO_W(TO_W)) u_lock_tmr (
    .clk(clk), .rst_n(rst_n), .run(ev_wait_lock),
    .limit(lock_lim_q), .expired(lock_expired)
  );

  phy_wait_timer #(.TO_W(TO_W)) u_stop_tmr (
    .clk(clk), .rst_n(rst_n), .run(ev_wait_stop),
    .limit(stop_lim_q), .expired(stop_expired)
  );

  phy_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start),
    .phy_lock(phy_lock), .phy_stop_clk(phy_stop_clk),
    .lock_expired(lock_expired), .stop_expired(stop_expired),
    .accept(ev_accept), .in_wait_lock(ev_wait_lock), .in_wait_stop(ev_wait_stop),
    .phy_ctrl(phy_ctrl), .phy_testclr(phy_testclr),
    .busy(busy), .done(done), .err_lock(err_lock), .err_stop(err_stop)
  );
endmodule

// File: rtl/phy_bringup_seq_chk.sv
module phy_bringup_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] phy_ctrl,
  input logic       phy_testclr,
  input logic       busy,
  input logic       done,
  input logic       err_lock,
  input logic       err_stop,
  input logic       phy_lock,
  input logic       phy_stop_clk,
  input logic       ev_accept,
  input logic       ev_wait_lock,
  input logic       ev_wait_stop
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done) |-> (phy_ctrl == 4'h0 && !phy_testclr));

  p_testclr_ctrl_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phy_testclr |-> (phy_ctrl == 4'h0));

  p_testclr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phy_testclr |=> !phy_testclr);

  p_ctrl_all_or_none_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_ctrl == 4'h0) || (phy_ctrl == 4'hF));

  p_enable_after_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_ctrl[0]) |-> $past(phy_testclr, 2));

  p_stop_after_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_wait_stop) |-> $past(ev_wait_lock));

  p_lock_err_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_lock) |-> $past(ev_wait_lock && !phy_lock));

  p_lock_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_lock && !ev_accept) |=> err_lock);

  p_stop_err_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_stop) |-> $past(ev_wait_stop && !phy_stop_clk));

  p_done_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && phy_ctrl == 4'hF));

  p_restart_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> (busy && !done && !err_lock && !err_stop));
endmodule

bind phy_bringup_seq phy_bringup_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phy_ctrl(phy_ctrl), .phy_testclr(phy_testclr),
  .busy(busy), .done(done), .err_lock(err_lock), .err_stop(err_stop),
  .phy_lock(phy_lock), .phy_stop_clk(phy_stop_clk),
  .ev_accept(ev_accept), .ev_wait_lock(ev_wait_lock), .ev_wait_stop(ev_wait_stop)
);

// File: tb/phy_bringup_seq_test.sv
`timescale 1ns/1ps
module phy_bringup_seq_test;
  localparam int TO_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [TO_W-1:0] lock_limit = '0, stop_limit = '0;
  logic [1:0] cfg_lanes_m1 = '0;
  logic [7:0] cfg_stop_wait = '0;
  logic [9:0] cfg_hs2lp = '0, cfg_lp2hs = '0;
  logic phy_lock, phy_stop_clk;
  logic [3:0] phy_ctrl;
  logic phy_testclr, busy, done, err_lock, err_stop;
  logic [15:0] if_cfg;
  logic [31:0] tmr_cfg;
  logic [3:0] l_ctrl;
  logic l_tclr, l_busy, l_done, l_el, l_es;
  logic [15:0] l_if;
  logic [31:0] l_tmr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  phy_bringup_seq #(.NEW_TIMERS(1'b1), .TO_W(TO_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .lock_limit(lock_limit), .stop_limit(stop_limit),
    .cfg_lanes_m1(cfg_lanes_m1), .cfg_stop_wait(cfg_stop_wait),
    .cfg_hs2lp(cfg_hs2lp), .cfg_lp2hs(cfg_lp2hs),
    .phy_lock(phy_lock), .phy_stop_clk(phy_stop_clk),
    .phy_ctrl(phy_ctrl), .phy_testclr(phy_testclr), .busy(busy), .done(done),
    .err_lock(err_lock), .err_stop(err_stop), .if_cfg(if_cfg), .tmr_cfg(tmr_cfg)
  );

  // second variant, used only for the narrow timer layout
  phy_bringup_seq #(.NEW_TIMERS(1'b0), .TO_W(TO_W)) uut_legacy (
    .clk(clk), .rst_n(rst_n), .start(start),
    .lock_limit(lock_limit), .stop_limit(stop_limit),
    .cfg_lanes_m1(cfg_lanes_m1), .cfg_stop_wait(cfg_stop_wait),
    .cfg_hs2lp(cfg_hs2lp), .cfg_lp2hs(cfg_lp2hs),
    .phy_lock(phy_lock), .phy_stop_clk(phy_stop_clk),
    .phy_ctrl(l_ctrl), .phy_testclr(l_tclr), .busy(l_busy), .done(l_done),
    .err_lock(l_el), .err_stop(l_es), .if_cfg(l_if), .tmr_cfg(l_tmr)
  );

  // PHY stub: status follows a count of cycles with all control lines on
  int en_cnt = 0;
  int lk_dly = 0;
  int st_dly = 0;
  always @(posedge clk) begin
    if (phy_ctrl != 4'hF) en_cnt <= 0;
    else                  en_cnt <= en_cnt + 1;
  end
  assign phy_lock     = (phy_ctrl == 4'hF) && (en_cnt >= lk_dly);
  assign phy_stop_clk = (phy_ctrl == 4'hF) && (en_cnt >= st_dly);

  typedef struct {
    logic [3:0] ctrl;
    logic       tclr, bsy, dn, el, es;
    string      tag;
  } exp_t;
  exp_t q[$];

  // monitor: one expected item per cycle, sampled at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (phy_ctrl !== e.ctrl || phy_testclr !== e.tclr || busy !== e.bsy ||
            done !== e.dn || err_lock !== e.el || err_stop !== e.es) begin
          errors++;
          $display("FAIL %s: ctrl/tclr/busy/done/el/es actual %h %b %b %b %b %b expected %h %b %b %b %b %b",
                   e.tag, phy_ctrl, phy_testclr, busy, done, err_lock, err_stop,
                   e.ctrl, e.tclr, e.bsy, e.dn, e.el, e.es);
        end
      end
    end
  end

  task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: one full run with PHY delays L,S and limits T,Ts
  task automatic run_seq(input int L, input int T, input int S, input int Ts,
                         input bit bump, input logic [1:0] ln, input logic [7:0] sw,
                         input logic [9:0] h2l, input logic [9:0] l2h);
    int m1, ws, a, k2;
    bit el, es;
    m1 = (L <= T) ? L : T;
    el = (L > T);
    ws = 4 + m1;
    a  = (ws > 3 + S) ? ws : 3 + S;
    es = (a > ws + Ts);
    k2 = es ? ws + Ts : a;
    @(posedge clk); #1;
    lk_dly = L; st_dly = S;
    lock_limit = TO_W'(T); stop_limit = TO_W'(Ts);
    cfg_lanes_m1 = ln; cfg_stop_wait = sw; cfg_hs2lp = h2l; cfg_lp2hs = l2h;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int k = 0; k <= k2 + 3; k++) begin
      exp_t e;
      e.ctrl = (k >= 3) ? 4'hF : 4'h0;
      e.tclr = (k == 1);
      e.bsy  = (k <= k2);
      e.dn   = (k > k2);
      e.el   = el && (k >= ws);
      e.es   = es && (k > k2);
      if (k == 0)      e.tag = "R9";
      else if (k < 3)  e.tag = "R2";
      else if (k <= k2) e.tag = bump ? "R8" : "R4";
      else             e.tag = "R7";
      q.push_back(e);
    end
    // change captured inputs mid-run (R10, R11 must not follow)
    cfg_lanes_m1 = ~ln; cfg_stop_wait = ~sw; cfg_hs2lp = ~h2l; cfg_lp2hs = ~l2h;
    lock_limit = '1; stop_limit = '1;
    if (bump) begin
      // R8: start while busy
      repeat (3) @(posedge clk);
      #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    while (q.size() > 0) @(posedge clk);
    check_val("R10", {16'b0, if_cfg}, {16'b0, sw, 6'b0, ln});
    check_val("R11", tmr_cfg, {6'b0, h2l, 6'b0, l2h});
    check_val("R11", l_tmr, {h2l[7:0], l2h[7:0], 16'b0});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check_val("R1", {26'b0, phy_ctrl, phy_testclr, busy}, 32'h0);
    check_val("R1", {29'b0, done, err_lock, err_stop}, 32'h0);
    check_val("R1", {16'b0, if_cfg}, 32'h0);
    check_val("R1", tmr_cfg, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check_val("R1", {26'b0, phy_ctrl, phy_testclr, busy}, 32'h0);

    run_seq(2, 10, 5, 10, 1'b0, 2'd3, 8'h20, 10'h155, 10'h0AA);   // R4 normal
    run_seq(0, 4, 0, 4, 1'b0, 2'd0, 8'h01, 10'h3FF, 10'h001);     // immediate status
    run_seq(1000, 6, 3, 8, 1'b0, 2'd1, 8'h7E, 10'h123, 10'h321);  // R5 lock timeout
    run_seq(1, 5, 1000, 4, 1'b0, 2'd2, 8'hC3, 10'h2A5, 10'h15A);  // R6 stop timeout
    run_seq(1000, 3, 1000, 2, 1'b1, 2'd3, 8'h99, 10'h0F0, 10'h30F); // both, R8
    run_seq(6, 6, 20, 10, 1'b0, 2'd1, 8'h44, 10'h011, 10'h022);   // R5 boundary: lock at limit
    run_seq(1, 0, 5, 0, 1'b0, 2'd0, 8'h05, 10'h100, 10'h200);     // zero limits, R9 clears errs
    run_seq(3, 8, 12, 8, 1'b1, 2'd2, 8'hA5, 10'h2C4, 10'h1B3);    // R6 boundary: stop at limit

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule